// File: doc/BRIEF.md
# Cascadable Down-Counting Timer Pair

This block holds two programmable down-counting timers: a narrow one of 24 bits and a wide one of 32 bits. Each timer picks its count rate from one of four tick-enable inputs, all derived from the system clock. Each has a setting register that it reloads from, a control register, and a read-only view of its count. When a timer reaches zero on a step, it reloads its setting and raises a terminal-count event. The event sets a sticky status bit. The status bit reaches an interrupt output only when that timer's interrupt-enable bit is set.

A combine bit in the narrow timer's control register chains the two timers into one free-running wide counter. In that mode the narrow timer acts as a divider: each of its terminal counts steps the wide timer by one, and the wide timer ignores its own rate source. The wide timer's observed value is then the bitwise inverse of its down-count, so software sees a count that rises. When the wide count wraps, it reloads, which puts the observed value back at the inverse of the setting, and it keeps running. For example, a setting of 7 on the 8 MHz tick and a wide setting of all ones give a microsecond counter that starts at zero.

Software reaches the timers over a simple bus. A write takes effect at the clock edge that samples it. Reads are combinational.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset both control registers read 0 (disabled, combine clear). The narrow setting reads 0x00FFFFFF and the wide setting reads 0xFFFFFFFF. Both observed values and the status register read 0, and both interrupt outputs are low.
- R2: Control bits [5:4] select the rate source: 0 = 32.768 kHz tick, 1 = 1.024 kHz tick, 2 = 32 Hz tick, 3 = 8 MHz tick. An enabled timer steps only on a pulse of its selected tick. Pulses on the other three ticks leave it unchanged.
- R3: Control bit 0 enables counting. While it is clear, ticks leave the count unchanged. Setting it again without a restart continues from the held value.
- R4: Writing a control word with bit 1 set reloads the count from the setting register; bit 1 always reads back 0. Writing bits 0 and 1 together enables the timer and restarts it in one write.
- R5: In standalone mode, a step taken at count 0 reloads the setting, so a setting of N gives one terminal count every N+1 steps. The terminal count sets the timer's status bit.
- R6: Writing the setting register does not change the running count. The new value is taken at the next restart or terminal-count reload.
- R7: Status is at address 6, bit 0 for the narrow timer and bit 1 for the wide timer. Writing 1 to a bit clears it. Each interrupt output equals its status bit ANDed with control bit 2 of the same timer.
- R8: With control bit 3 of the narrow timer set, the wide timer steps once per narrow-timer terminal count and ignores its own rate ticks.
- R9: In combined mode the wide timer's observed value is the bitwise inverse of its down-count. With a setting of 0xFFFFFFFF and a restart, it reads 0 and then rises by one per narrow period.
- R10: In combined mode, a step taken when the wide observed value is 0xFFFFFFFF reloads it to the inverse of the wide setting. Counting continues, and wide status bit 1 is set.
- R11: The narrow timer keeps only the low 24 bits of a setting write, and its setting and observed value read back with bits [31:24] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | 32.768 kHz rate tick enable (source 0) |
| tick_1k | input | 1 | 1.024 kHz rate tick enable (source 1) |
| tick_32hz | input | 1 | 32 Hz rate tick enable (source 2) |
| tick_8m | input | 1 | 8 MHz rate tick enable (source 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 narrow ctrl, 1 narrow setting, 2 narrow observed, 3 wide ctrl, 4 wide setting, 5 wide observed, 6 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lo | output | 1 | Narrow timer terminal-count interrupt |
| irq_hi | output | 1 | Wide timer terminal-count interrupt |

## Verification
The count function is exercised with five kinds of stimulus:

- Each of the four rate sources in turn, with pulses on the non-selected ticks. This separates a correct source decode from a swapped or merged one.
- Runs across zero with small settings. These confirm the N+1 period and the reload value. They also show that a mid-run setting write waits for the reload rather than taking effect at once.
- Disable/re-enable sequences with no restart. These tell a held count apart from one that was reset.
- Combined runs with a divider setting of 7. These show that the wide value rises once per eight ticks and stays put when its own ticks are pulsed.
- A combined run with a wide setting of 1 and a divider of 0. This reaches the wrap within a few ticks, exposing the inverted reload and the wide status flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NSRC = 4;
  localparam int CTL_EN = 0;
  localparam int CTL_RST = 1;
  localparam int CTL_IE = 2;
  localparam int CTL_CMB = 3;
  localparam int CTL_SRC = 4;

  typedef enum logic [1:0] {
    SRC_32K = 2'd0,
    SRC_1K = 2'd1,
    SRC_32HZ = 2'd2,
    SRC_8M = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    A_LO_CTL = 3'd0,
    A_LO_SET = 3'd1,
    A_LO_OBS = 3'd2,
    A_HI_CTL = 3'd3,
    A_HI_SET = 3'd4,
    A_HI_OBS = 3'd5,
    A_STS = 3'd6
  } addr_e;

  // pick the tick of the chosen source
  function automatic logic pick_tick(input src_e s, input logic [NSRC-1:0] t);
    return t[s];
  endfunction
endpackage

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel
  import tmr_pkg::*;
(
  input  src_e              src,
  input  logic [NSRC-1:0]   ticks,
  output logic              tick
);
  always_comb tick = pick_tick(src, ticks);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 24,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctl,
  input  logic            wr_set,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] ticks,
  input  logic            use_ext,
  input  logic            ext_step,
  output logic            en,
  output logic            ie,
  output src_e            src,
  output logic [W-1:0]    set,
  output logic [W-1:0]    cnt,
  output logic            restart,
  output logic            tc
);
  logic own_tick;
  logic step;

  tmr_rate_sel u_sel (.src(src), .ticks(ticks), .tick(own_tick));

  assign restart = wr_ctl && wdata[CTL_RST];
  assign step    = use_ext ? ext_step : own_tick;
  assign tc      = en && step && (cnt == '0) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      ie  <= 1'b0;
      src <= SRC_32K;
      set <= '1;
    end else begin
      if (wr_ctl) begin
        en  <= wdata[CTL_EN];
        ie  <= wdata[CTL_IE];
        src <= src_e'(wdata[CTL_SRC +: 2]);
      end
      if (wr_set) set <= wdata[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= set;
    else if (en && step)     cnt <= (cnt == '0) ? set : cnt - 1'b1;
  end
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int LO_W = 24,
  parameter int HI_W = 32,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32k,
  input  logic          tick_1k,
  input  logic          tick_32hz,
  input  logic          tick_8m,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam int NT = 2;

  logic [NSRC-1:0] ticks;
  assign ticks = {tick_8m, tick_32hz, tick_1k, tick_32k};

  logic            combine;
  logic [NT-1:0]   sts;
  logic            lo_en, hi_en, lo_ie, hi_ie;
  src_e            lo_src, hi_src;
  logic [LO_W-1:0] lo_set, lo_cnt;
  logic [HI_W-1:0] hi_set, hi_cnt, hi_obs;
  logic            lo_restart, hi_restart, lo_tc, hi_tc;
  logic            wr_sts;

  assign wr_sts = bus_wr && (bus_addr == A_STS);

  tmr_chan #(.W(LO_W), .DW(DW)) u_lo (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(bus_wr && bus_addr == A_LO_CTL),
    .wr_set(bus_wr && bus_addr == A_LO_SET),
    .wdata(bus_wdata), .ticks(ticks),
    .use_ext(1'b0), .ext_step(1'b0),
    .en(lo_en), .ie(lo_ie), .src(lo_src), .set(lo_set), .cnt(lo_cnt),
    .restart(lo_restart), .tc(lo_tc)
  );

  tmr_chan #(.W(HI_W), .DW(DW)) u_hi (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl(bus_wr && bus_addr == A_HI_CTL),
    .wr_set(bus_wr && bus_addr == A_HI_SET),
    .wdata(bus_wdata), .ticks(ticks),
    .use_ext(combine), .ext_step(lo_tc),
    .en(hi_en), .ie(hi_ie), .src(hi_src), .set(hi_set), .cnt(hi_cnt),
    .restart(hi_restart), .tc(hi_tc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) combine <= 1'b0;
    else if (bus_wr && bus_addr == A_LO_CTL) combine <= bus_wdata[CTL_CMB];
  end

  logic [NT-1:0] tc_vec;
  assign tc_vec = {hi_tc, lo_tc};

  for (genvar i = 0; i < NT; i++) begin : g_sts
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts[i] <= 1'b0;
      else sts[i] <= (sts[i] && !(wr_sts && bus_wdata[i])) || tc_vec[i];
    end
  end

  assign hi_obs = combine ? ~hi_cnt : hi_cnt;
  assign irq_lo = sts[0] && lo_ie;
  assign irq_hi = sts[1] && hi_ie;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LO_CTL: begin
        bus_rdata[CTL_EN]       = lo_en;
        bus_rdata[CTL_IE]       = lo_ie;
        bus_rdata[CTL_CMB]      = combine;
        bus_rdata[CTL_SRC +: 2] = lo_src;
      end
      A_LO_SET: bus_rdata[LO_W-1:0] = lo_set;
      A_LO_OBS: bus_rdata[LO_W-1:0] = lo_cnt;
      A_HI_CTL: begin
        bus_rdata[CTL_EN]       = hi_en;
        bus_rdata[CTL_IE]       = hi_ie;
        bus_rdata[CTL_SRC +: 2] = hi_src;
      end
      A_HI_SET: bus_rdata[HI_W-1:0] = hi_set;
      A_HI_OBS: bus_rdata[HI_W-1:0] = hi_obs;
      A_STS:    bus_rdata[NT-1:0]   = sts;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int LO_W = 24,
  parameter int HI_W = 32,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            lo_en,
  input logic            hi_en,
  input logic            lo_restart,
  input logic            hi_restart,
  input logic            lo_tc,
  input logic            hi_tc,
  input logic            combine,
  input logic [LO_W-1:0] lo_set,
  input logic [LO_W-1:0] lo_cnt,
  input logic [HI_W-1:0] hi_set,
  input logic [HI_W-1:0] hi_cnt,
  input logic [1:0]      sts
);
  // R3: a disabled timer holds its count
  a_r3_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_en && !lo_restart) |=> $stable(lo_cnt));
  a_r3_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_en && !hi_restart) |=> $stable(hi_cnt));
  // R4: restart loads the setting
  a_r4_restart_lo: assert property (@(posedge clk) disable iff (!rst_n)
    lo_restart |=> lo_cnt == $past(lo_set));
  a_r4_restart_hi: assert property (@(posedge clk) disable iff (!rst_n)
    hi_restart |=> hi_cnt == $past(hi_set));
  // R5: terminal count reloads and sets status
  a_r5_reload_lo: assert property (@(posedge clk) disable iff (!rst_n)
    lo_tc |=> (lo_cnt == $past(lo_set)) && sts[0]);
  // R7: write-one clears status when no new event arrives
  a_r7_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd6 && bus_wdata[0] && !lo_tc) |=> !sts[0]);
  // R8: in combined mode the wide count moves only on narrow terminal counts
  a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (combine && !hi_restart && !lo_tc) |=> $stable(hi_cnt));
  // R10: wrap in combined mode raises wide status
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (combine && hi_tc) |=> sts[1] && (hi_cnt == $past(hi_set)));
endmodule

bind tmr_pair_top tmr_pair_chk #(.LO_W(LO_W), .HI_W(HI_W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .lo_en(lo_en), .hi_en(hi_en), .lo_restart(lo_restart), .hi_restart(hi_restart),
  .lo_tc(lo_tc), .hi_tc(hi_tc), .combine(combine), .lo_set(lo_set), .lo_cnt(lo_cnt),
  .hi_set(hi_set), .hi_cnt(hi_cnt), .sts(sts)
);

// File: tb/tb_tmr_pair_top.sv
module tb_tmr_pair_top;
  logic clk = 0;
  logic rst_n = 0;
  logic tick_32k = 0, tick_1k = 0, tick_32hz = 0, tick_8m = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq_lo, irq_hi;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_pair_top dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .tick_1k(tick_1k),
    .tick_32hz(tick_32hz), .tick_8m(tick_8m), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    {tick_8m, tick_32hz, tick_1k, tick_32k} = m;
    @(negedge clk);
    {tick_8m, tick_32hz, tick_1k, tick_32k} = 4'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 lo ctrl", d, 0);
    rd(1, d); chk("R1 lo set", d, 32'h00FF_FFFF);
    rd(2, d); chk("R1 lo obs", d, 0);
    rd(3, d); chk("R1 hi ctrl", d, 0);
    rd(4, d); chk("R1 hi set", d, 32'hFFFF_FFFF);
    rd(5, d); chk("R1 hi obs", d, 0);
    rd(6, d); chk("R1 status", d, 0);
    chk("R1 irqs", {30'b0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_sources();
    logic [31:0] d;
    wr(1, 5);
    for (int s = 0; s < 4; s++) begin
      wr(0, 32'h3 | (s << 4));
      rd(2, d); chk("R4 restart loads setting", d, 5);
      for (int o = 0; o < 4; o++) if (o != s) pulse(4'b1 << o);
      rd(2, d); chk("R2 other sources ignored", d, 5);
      pulse(4'b1 << s);
      rd(2, d); chk("R2 selected source steps", d, 4);
    end
  endtask

  task automatic t_terminal();
    logic [31:0] d;
    wr(6, 3);
    wr(1, 2);
    wr(0, 32'h37);
    rd(0, d); chk("R4 restart bit reads 0", d, 32'h35);
    pulse(4'h8); pulse(4'h8);
    rd(2, d); chk("R5 counts down to 0", d, 0);
    rd(6, d); chk("R5 no status before tc", d, 0);
    pulse(4'h8);
    rd(2, d); chk("R5 reload after N+1 steps", d, 2);
    rd(6, d); chk("R5 status set", d, 1);
    chk("R7 irq_lo with enable", irq_lo, 1);
    wr(6, 1);
    rd(6, d); chk("R7 W1C clears", d, 0);
    chk("R7 irq_lo cleared", irq_lo, 0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    pulse(4'h8);
    wr(0, 32'h34);
    pulse(4'h8); pulse(4'h8);
    rd(2, d); chk("R3 disabled holds", d, 1);
    wr(0, 32'h35);
    pulse(4'h8);
    rd(2, d); chk("R3 resume without restart", d, 0);
  endtask

  task automatic t_setting();
    logic [31:0] d;
    wr(1, 3);
    wr(0, 32'h33);
    pulse(4'h8);
    wr(1, 9);
    rd(2, d); chk("R6 set write no effect", d, 2);
    pulse(4'h8); pulse(4'h8);
    rd(2, d); chk("R6 still old count", d, 0);
    pulse(4'h8);
    rd(2, d); chk("R6 new set on reload", d, 9);
    wr(1, 32'hABCD_EF12);
    rd(1, d); chk("R11 narrow set width", d, 32'h00CD_EF12);
  endtask

  task automatic t_combined();
    logic [31:0] d;
    wr(0, 0);
    wr(4, 32'hFFFF_FFFF);
    wr(3, 32'h3);
    wr(1, 7);
    wr(0, 32'h3B);
    rd(5, d); chk("R9 obs starts at 0", d, 0);
    repeat (7) pulse(4'h8);
    rd(5, d); chk("R8 no step before divider period", d, 0);
    pulse(4'h8);
    rd(5, d); chk("R8 one step per 8 ticks", d, 1);
    pulse(4'h1); pulse(4'h1);
    rd(5, d); chk("R8 own ticks ignored", d, 1);
    repeat (8) pulse(4'h8);
    rd(5, d); chk("R9 increments", d, 2);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(6, 3);
    wr(4, 1);
    wr(3, 32'h7);
    rd(5, d); chk("R10 start at inverse", d, 32'hFFFF_FFFE);
    wr(1, 0);
    wr(0, 32'h3B);
    pulse(4'h8);
    rd(5, d); chk("R9 reach all ones", d, 32'hFFFF_FFFF);
    rd(6, d); chk("R10 no hi status yet", d & 2, 0);
    pulse(4'h8);
    rd(5, d); chk("R10 reload inverse", d, 32'hFFFF_FFFE);
    rd(6, d); chk("R10 hi status set", d & 2, 2);
    chk("R7 irq_hi", irq_hi, 1);
    pulse(4'h8);
    rd(5, d); chk("R10 keeps counting", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sources();
    t_terminal();
    t_hold();
    t_setting();
    t_combined();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule